// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single memory requests from a core into accesses on an external 16-bit bus. The low half of the address and the data share the same lines, and four further address lines are driven on their own. Each access runs through an address phase, a data phase, optional stretch phases and a final phase. A wait input from the memory side holds the access in the stretch phase for as long as it stays asserted. Strobe outputs mark when the shared lines carry an address and when they carry data. A read/write status line and one enable per byte lane go with every access, so a single-byte transfer selects one half of the data path.

The core raises a request with a 20-bit window address (chip-select decoding happens outside), write data, a write flag and a lane mask. It keeps the request up until it sees a one-cycle ready pulse. Read data comes back on that pulse. An external master can take the bus with a hold request. The block grants it only between accesses, answers with an acknowledge, and drops every output enable while the other master owns the bus. One recovery cycle follows before it starts another access. The block drives pad enables rather than tri-state nets: a low enable means the pad floats.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, no access is running: both strobes are low, the hold acknowledge is low, ready is low, the shared-line enable is low and the control enable is high.
- R2: A request seen while idle starts an access. The access runs one address cycle, one data cycle, any stretch cycles and one final cycle, in that order. The data strobe is high in the data, stretch and final cycles.
- R3: In the address cycle the address strobe is high, the shared lines carry request address bits 15:0 and the upper address lines carry bits 19:16. The two strobes are never high together.
- R4: In a write, the read status line (1 = read, 0 = write) is low for the whole access and the shared lines carry the write data from the data cycle through the final cycle. Outside an access, the read status line is high.
- R5: In a read, the shared-line enable is low from the data cycle onward. The value on the bus input at the end of the final cycle is returned on the read data output.
- R6: If the wait input is high at the end of the data cycle, a stretch cycle follows. Stretching repeats while wait stays high, and the final cycle follows the first clock edge with wait low. An access with N stretch cycles shows ready N+4 clocks after the request is first seen.
- R7: Lane enable bit 1 (upper byte) and bit 0 (lower byte) equal the request mask bits 1 and 0 from the address cycle through the final cycle. Both are low otherwise.
- R8: Ready is high for exactly the one cycle after the final cycle.
- R9: The hold request is sampled on the falling clock edge. It is granted only from idle or at the end of a final cycle, never inside an access. While held, the acknowledge is high and both the shared-line enable and the control enable are low.
- R10: When the sampled hold request drops, one recovery cycle passes with acknowledge low, controls driven and no strobe. Then the block is idle. A request that is waiting reaches its address cycle three clocks after the hold request drops.
- R11: When a hold request and a core request are both present at an idle boundary, the hold is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core request, held until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 20 | Window address |
| core_wdata | input | 16 | Write data |
| core_mask | input | 2 | Byte lane mask, bit 1 upper, bit 0 lower |
| core_ready | output | 1 | One-cycle completion pulse |
| core_rdata | output | 16 | Data returned by the last read |
| bus_ad_o | output | 16 | Shared address/data value |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | 16 | Value seen on the shared lines |
| bus_xaddr | output | 4 | Upper address lines |
| bus_addr_stb | output | 1 | Address strobe, high = address valid |
| bus_data_stb | output | 1 | Data strobe, high = data phase |
| bus_rd | output | 1 | Read status, 1 = read, 0 = write |
| bus_lane_en | output | 2 | Byte lane enables, bit 1 upper |
| bus_ctl_oe | output | 1 | Drive enable for upper address, strobes, status and lanes |
| bus_stretch | input | 1 | Wait request from the memory side |
| bus_hold_req | input | 1 | Bus request from an external master |
| bus_hold_ack | output | 1 | Bus granted to the external master |

## Verification
All outputs are decoded straight from the registered phase. A wrong phase shows at the strobes, enables or acknowledge in the same cycle the phase goes wrong, and the per-clock model comparison catches it at once. A latch fault in the address or data shows only while that field is on the lines. A lost capture of read data shows in the ready cycle. A hold granted inside an access shows as the acknowledge rising while a strobe would still be expected.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DATA  = 3'd2,
    PH_WAIT  = 3'd3,
    PH_LAST  = 3'd4,
    PH_HELD  = 3'd5,
    PH_RECOV = 3'd6
  } mxb_phase_e;

  function automatic logic ph_in_data(input mxb_phase_e p);
    return (p == PH_DATA) || (p == PH_WAIT) || (p == PH_LAST);
  endfunction

  function automatic logic ph_in_access(input mxb_phase_e p);
    return (p == PH_ADDR) || ph_in_data(p);
  endfunction

  function automatic logic ph_boundary(input mxb_phase_e p);
    return (p == PH_IDLE) || (p == PH_LAST);
  endfunction

  function automatic logic ph_ad_drive(input mxb_phase_e p, input logic wr);
    return (p == PH_ADDR) || (wr && ph_in_data(p));
  endfunction

  function automatic mxb_phase_e ph_next(input mxb_phase_e p, input logic req,
                                         input logic hold, input logic stretch);
    mxb_phase_e n;
    case (p)
      PH_IDLE:          n = hold ? PH_HELD : (req ? PH_ADDR : PH_IDLE);
      PH_ADDR:          n = PH_DATA;
      PH_DATA, PH_WAIT: n = stretch ? PH_WAIT : PH_LAST;
      PH_LAST:          n = hold ? PH_HELD : PH_IDLE;
      PH_HELD:          n = hold ? PH_HELD : PH_RECOV;
      default:          n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mxb_hold_sync.sv
module mxb_hold_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_i,
  output logic hold_o
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_o <= 1'b0;
    else        hold_o <= hold_req_i;
  end

endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
  import mxb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int XA_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [DATA_W+XA_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [DATA_W/8-1:0]       mask_i,
  input  logic                      stretch_i,
  input  logic                      hold_i,
  input  logic [DATA_W-1:0]         ad_in_i,
  output mxb_phase_e                phase_o,
  output logic [DATA_W+XA_W-1:0]    addr_o,
  output logic                      we_o,
  output logic [DATA_W-1:0]         wdata_o,
  output logic [DATA_W/8-1:0]       mask_o,
  output logic                      ready_o,
  output logic [DATA_W-1:0]         rdata_o
);

  mxb_phase_e phase_q, phase_d;
  logic start_acc, end_acc, cap_read, grant_hold;

  assign phase_d    = ph_next(phase_q, req_i, hold_i, stretch_i);
  assign start_acc  = (phase_q == PH_IDLE) && (phase_d == PH_ADDR);
  assign end_acc    = (phase_q == PH_LAST);
  assign cap_read   = end_acc && !we_o;
  assign grant_hold = ph_boundary(phase_q) && hold_i;
  assign phase_o    = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_o  <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
      mask_o  <= '0;
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      phase_q <= phase_d;
      ready_o <= end_acc;
      if (start_acc) begin
        addr_o  <= addr_i;
        we_o    <= we_i;
        wdata_o <= wdata_i;
        mask_o  <= mask_i;
      end
      if (cap_read) rdata_o <= ad_in_i;
    end
  end

  assert_addr_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |=> (phase_q == PH_DATA));

  assert_stretch_needs_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> $past(stretch_i));

  assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  assert_hold_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HELD && $past(phase_q) != PH_HELD) |->
      ($past(phase_q) == PH_IDLE || $past(phase_q) == PH_LAST));

  assert_grant_takes_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_hold |=> (phase_q == PH_HELD));

  assert_recov_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RECOV) |=> (phase_q == PH_IDLE));

  assert_access_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |-> ($past(phase_q) == PH_IDLE && !$past(hold_i)));

endmodule

// File: rtl/mxb_pins.sv
module mxb_pins
  import mxb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int XA_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  mxb_phase_e                phase_i,
  input  logic [DATA_W+XA_W-1:0]    addr_i,
  input  logic                      we_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [DATA_W/8-1:0]       mask_i,
  output logic [DATA_W-1:0]         ad_o,
  output logic                      ad_oe_o,
  output logic [XA_W-1:0]           xaddr_o,
  output logic                      addr_stb_o,
  output logic                      data_stb_o,
  output logic                      rd_o,
  output logic [DATA_W/8-1:0]       lane_o,
  output logic                      ctl_oe_o,
  output logic                      hold_ack_o
);

  localparam int LANES = DATA_W / 8;

  logic in_acc;

  assign in_acc     = ph_in_access(phase_i);
  assign addr_stb_o = (phase_i == PH_ADDR);
  assign data_stb_o = ph_in_data(phase_i);
  assign ad_oe_o    = ph_ad_drive(phase_i, we_i);
  assign ad_o       = (phase_i == PH_ADDR) ? addr_i[DATA_W-1:0] : wdata_i;
  assign xaddr_o    = addr_i[DATA_W +: XA_W];
  assign rd_o       = !(in_acc && we_i);
  assign hold_ack_o = (phase_i == PH_HELD);
  assign ctl_oe_o   = (phase_i != PH_HELD);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_o[g] = in_acc && mask_i[g];
  end

  assert_float_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack_o |-> (!ad_oe_o && !ctl_oe_o));

  assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_stb_o && data_stb_o));

  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb_o && rd_o) |-> !ad_oe_o);

  assert_lanes_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_stb_o || data_stb_o) |-> (lane_o == '0));

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mxb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int XADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       core_req,
  input  logic                       core_we,
  input  logic [DATA_W+XADDR_W-1:0]  core_addr,
  input  logic [DATA_W-1:0]          core_wdata,
  input  logic [DATA_W/8-1:0]        core_mask,
  output logic                       core_ready,
  output logic [DATA_W-1:0]          core_rdata,
  output logic [DATA_W-1:0]          bus_ad_o,
  output logic                       bus_ad_oe,
  input  logic [DATA_W-1:0]          bus_ad_i,
  output logic [XADDR_W-1:0]         bus_xaddr,
  output logic                       bus_addr_stb,
  output logic                       bus_data_stb,
  output logic                       bus_rd,
  output logic [DATA_W/8-1:0]        bus_lane_en,
  output logic                       bus_ctl_oe,
  input  logic                       bus_stretch,
  input  logic                       bus_hold_req,
  output logic                       bus_hold_ack
);

  localparam int WIN_W = DATA_W + XADDR_W;
  localparam int LANES = DATA_W / 8;

  logic               hold_s;
  mxb_phase_e         phase;
  logic [WIN_W-1:0]   lat_addr;
  logic               lat_we;
  logic [DATA_W-1:0]  lat_wdata;
  logic [LANES-1:0]   lat_mask;

  mxb_hold_sync u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req_i (bus_hold_req),
    .hold_o     (hold_s)
  );

  mxb_seq #(.DATA_W(DATA_W), .XA_W(XADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (core_req),
    .we_i      (core_we),
    .addr_i    (core_addr),
    .wdata_i   (core_wdata),
    .mask_i    (core_mask),
    .stretch_i (bus_stretch),
    .hold_i    (hold_s),
    .ad_in_i   (bus_ad_i),
    .phase_o   (phase),
    .addr_o    (lat_addr),
    .we_o      (lat_we),
    .wdata_o   (lat_wdata),
    .mask_o    (lat_mask),
    .ready_o   (core_ready),
    .rdata_o   (core_rdata)
  );

  mxb_pins #(.DATA_W(DATA_W), .XA_W(XADDR_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase),
    .addr_i     (lat_addr),
    .we_i       (lat_we),
    .wdata_i    (lat_wdata),
    .mask_i     (lat_mask),
    .ad_o       (bus_ad_o),
    .ad_oe_o    (bus_ad_oe),
    .xaddr_o    (bus_xaddr),
    .addr_stb_o (bus_addr_stb),
    .data_stb_o (bus_data_stb),
    .rd_o       (bus_rd),
    .lane_o     (bus_lane_en),
    .ctl_oe_o   (bus_ctl_oe),
    .hold_ack_o (bus_hold_ack)
  );

endmodule

// File: tb/tb_mux_bus_ctrl.sv
module tb_mux_bus_ctrl;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        req, we;
  logic [19:0] addr;
  logic [15:0] wd, ad_in;
  logic [1:0]  mask;
  logic        stretch, hrq;
  logic        ready, ad_oe, astb, dstb, rd, ctl_oe, hack;
  logic [15:0] rdata, ad_out;
  logic [3:0]  xaddr;
  logic [1:0]  lanes;

  mux_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .core_req(req), .core_we(we), .core_addr(addr), .core_wdata(wd), .core_mask(mask),
    .core_ready(ready), .core_rdata(rdata),
    .bus_ad_o(ad_out), .bus_ad_oe(ad_oe), .bus_ad_i(ad_in), .bus_xaddr(xaddr),
    .bus_addr_stb(astb), .bus_data_stb(dstb), .bus_rd(rd), .bus_lane_en(lanes),
    .bus_ctl_oe(ctl_oe), .bus_stretch(stretch), .bus_hold_req(hrq), .bus_hold_ack(hack)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle,1 addr,2 data,3 stretch,4 final,5 held,6 recovery
  int          m_st = 0;
  logic [19:0] m_addr = '0;
  logic        m_we = 0;
  logic [15:0] m_wd = '0, m_rd = '0;
  logic [1:0]  m_mask = '0;
  logic        m_rdy = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_addr = '0; m_we = 0; m_wd = '0; m_mask = '0; m_rdy = 0; m_rd = '0;
    end else begin
      m_rdy = (m_st == 4);
      if (m_st == 4 && !m_we) m_rd = ad_in;
      case (m_st)
        0: if (hrq) m_st = 5;
           else if (req) begin m_st = 1; m_addr = addr; m_we = we; m_wd = wd; m_mask = mask; end
        1: m_st = 2;
        2, 3: m_st = stretch ? 3 : 4;
        4: m_st = hrq ? 5 : 0;
        5: m_st = hrq ? 5 : 6;
        default: m_st = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      bit acc, dat;
      acc = (m_st >= 1 && m_st <= 4);
      dat = (m_st >= 2 && m_st <= 4);
      chk("R3", "address strobe", astb, m_st == 1);
      chk("R2", "data strobe", dstb, dat);
      chk("R5", "shared drive enable", ad_oe, (m_st == 1) || (m_we && dat));
      if (m_st == 1) chk("R3", "low address", ad_out, m_addr[15:0]);
      if (m_we && dat) chk("R4", "write data", ad_out, m_wd);
      if (acc) chk("R3", "upper address", xaddr, m_addr[19:16]);
      chk("R4", "read status", rd, !(acc && m_we));
      chk("R7", "lane enables", lanes, acc ? m_mask : 2'b00);
      chk("R8", "ready", ready, m_rdy);
      chk("R5", "read data", rdata, m_rd);
      chk("R9", "hold ack", hack, m_st == 5);
      chk("R9", "control enable", ctl_oe, m_st != 5);
    end
  end

  // wait generator: holds stretch for the requested number of stretch cycles
  int wl_req = 0;
  int wl = 0;
  always @(posedge clk) begin
    #1;
    case (m_st)
      1: begin wl = wl_req; stretch = 1'b0; end
      2: stretch = (wl > 0);
      3: begin wl = wl - 1; stretch = (wl > 0); end
      default: stretch = 1'b0;
    endcase
  end

  task automatic acc(input logic [19:0] a, input logic w, input logic [15:0] d,
                     input logic [1:0] m, input int nw, input logic [15:0] rv);
    int cnt;
    cnt = 0;
    @(posedge clk); #1;
    addr = a; we = w; wd = d; mask = m; wl_req = nw; ad_in = rv; req = 1'b1;
    do begin @(posedge clk); #3; cnt++; end while (!ready && cnt < 100);
    req = 1'b0;
    chk("R6", "clocks from request to ready", cnt, nw + 4);
    if (!w) chk("R5", "returned read value", rdata, rv);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog R2: actual=running expected=finished");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 0; req = 0; we = 0; addr = '0; wd = '0; mask = '0; ad_in = '0; hrq = 0; stretch = 0;
    #12;
    chk("R1", "strobe a in reset", astb, 0);
    chk("R1", "strobe d in reset", dstb, 0);
    chk("R1", "ack in reset", hack, 0);
    chk("R1", "ready in reset", ready, 0);
    chk("R1", "shared enable in reset", ad_oe, 0);
    chk("R1", "control enable in reset", ctl_oe, 1);
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #3;
    chk("R1", "idle after reset", {astb, dstb, hack}, 3'b000);

    acc(20'hA1234, 1, 16'hBEEF, 2'b11, 0, 16'h0000);
    acc(20'h5F00E, 0, 16'h0000, 2'b01, 0, 16'hC3A5);
    acc(20'h30002, 1, 16'h1357, 2'b10, 2, 16'h0000);
    acc(20'hE7FFF, 0, 16'h0000, 2'b10, 3, 16'h9A0F);
    acc(20'h00001, 0, 16'h0000, 2'b11, 1, 16'hFFFF);

    // R9: hold raised mid-access is granted only after the final cycle
    @(posedge clk); #1;
    addr = 20'h8ABCD; we = 0; mask = 2'b11; wl_req = 1; ad_in = 16'h7E81; req = 1;
    @(posedge clk); #3;
    req = 0; hrq = 1;
    chk("R9", "no grant inside access", hack, 0);
    cnt = 0;
    do begin @(posedge clk); #3; cnt++; end while (!ready && cnt < 100);
    chk("R9", "held in ready cycle", hack, 1);
    chk("R5", "read under hold", rdata, 16'h7E81);
    repeat (3) @(posedge clk);

    // R10: release with a waiting request
    #1;
    addr = 20'h2468A; we = 1; wd = 16'h0F0F; mask = 2'b01; wl_req = 0; req = 1; hrq = 0;
    @(posedge clk); #3;
    chk("R10", "recovery ack low", hack, 0);
    chk("R10", "recovery controls driven", ctl_oe, 1);
    chk("R10", "recovery no strobe", astb, 0);
    cnt = 1;
    while (!astb && cnt < 20) begin @(posedge clk); #3; cnt++; end
    chk("R10", "clocks to address after release", cnt, 3);
    while (!ready && cnt < 40) begin @(posedge clk); #3; cnt++; end
    req = 0;

    // R11: hold and request together at idle
    @(posedge clk); #1;
    addr = 20'h13579; we = 0; mask = 2'b10; wl_req = 0; ad_in = 16'h4242; req = 1; hrq = 1;
    @(posedge clk); #3;
    chk("R11", "hold wins ack", hack, 1);
    chk("R11", "hold wins no strobe", astb, 0);
    repeat (2) @(posedge clk);
    #1 hrq = 0;
    cnt = 0;
    do begin @(posedge clk); #3; cnt++; end while (!ready && cnt < 100);
    req = 0;
    chk("R11", "deferred read done", rdata, 16'h4242);

    acc(20'hFFFFF, 1, 16'hA5A5, 2'b01, 0, 16'h0000);
    repeat (3) @(posedge clk);
    #4;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule